// File: doc/BRIEF.md
# Multi-Level Cell Sense Controller

This block reads one multi-level storage cell that holds one of 2^NBITS charge levels and turns it into an NBITS-bit value. It does not sense anything itself: it drives a reference selector and the control pins of external comparators, and it reads their decisions back. A start pulse launches one read. A one-cycle done pulse ends it, and the value stays on the output until the next read finishes.

Two sensing modes exist, and the mode is chosen when the read is launched. In the serial mode the block runs a binary search. It decides the most significant bit first, against the middle reference, and each later step halves the remaining range. Two comparators share the steps in turn, so one is precharging while the other makes its decision. A read in this mode takes NBITS decision steps. In the flash mode a bank of 2^NBITS-1 comparators fires once. Their thermometer word is converted to a value by counting its ones, so an isolated out-of-order bit (a bubble) still gives a value close to the true one.

Top module: `mlc_sense_top`

## Requirements
- R1: After reset, done_o, value_o, cmp_pre_o, cmp_strobe_o and par_strobe_o are all 0.
- R2: In serial mode (par_mode_i=0 when start_i is accepted), done_o is 1 in the cycle after the NBITS+3rd rising edge, counting the edge that accepts start_i as the first. At that point value_o equals the cell level L, where a comparator returns 1 exactly when L >= ref_sel_o.
- R3: In serial mode exactly NBITS comparator strobes occur, with the most significant bit first. At step s (0-based), ref_sel_o holds the bits of L above bit NBITS-1-s, a 1 at bit NBITS-1-s, and zeros below.
- R4: Step s strobes comparator s mod 2 (bit 0 or bit 1 of cmp_strobe_o). A comparator is strobed only in the cycle right after it was precharged. At most one comparator is strobed per cycle, and no comparator is precharged and strobed in the same cycle.
- R5: In flash mode (par_mode_i=1 when start is accepted), par_strobe_o pulses exactly once. done_o is 1 after the 3rd edge, counting the accepting edge as the first. value_o equals the number of ones in the thermometer word captured on the strobe edge, where therm_i bit k-1 means "level >= k", and this holds for bubbled words as well.
- R6: done_o is high for exactly one cycle. value_o changes only in the cycle where done_o is high and holds its value through the whole of the next read.
- R7: start_i and par_mode_i are ignored while a read is in progress. The running read finishes with its own timing, mode and result.
- R8: A flash read never precharges or strobes the two serial comparators. A serial read never pulses par_strobe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launch a read (accepted only when idle) |
| par_mode_i | input | 1 | 1 = flash (thermometer) mode, 0 = serial binary search |
| therm_i | input | 2^NBITS-1 | Flash comparator outputs, bit k-1 set when level >= k |
| cmp_res_i | input | 2 | Latched decisions of the two serial comparators |
| ref_sel_o | output | NBITS | Reference index k for the strobed serial comparator |
| cmp_pre_o | output | 2 | Precharge request per serial comparator |
| cmp_strobe_o | output | 2 | Decide strobe per serial comparator |
| par_strobe_o | output | 1 | Fire the flash comparator bank |
| done_o | output | 1 | One-cycle completion pulse |
| value_o | output | NBITS | Resolved cell value |

## Verification
Serial reads are run for every cell level. Checking the reference issued at each step separates a correct midpoint search from one that reaches the right answer by a wrong path, or that swaps the comparator order. Flash reads are run with all 2^(2^NBITS-1) thermometer words, clean and bubbled. This separates a count of the ones from a priority-encode of the highest set bit. Reads with a second start injected partway through show whether a busy read can be restarted or switched to the other mode.

// File: rtl/mlc_sense_pkg.sv
package mlc_sense_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RUN,
    ST_PSMP,
    ST_PENC
  } sense_st_e;
endpackage

// File: rtl/mlc_sense_therm_enc.sv
module mlc_sense_therm_enc #(
  parameter int NBITS = 3,
  localparam int NREF = (1 << NBITS) - 1
) (
  input  logic [NREF-1:0]  therm_i,
  output logic [NBITS-1:0] count_o
);
  // Counting ones tolerates bubbles; the maximum count NREF fits NBITS bits.
  always_comb begin
    count_o = '0;
    for (int i = 0; i < NREF; i++) begin
      count_o = count_o + NBITS'(therm_i[i]);
    end
  end
endmodule

// File: rtl/mlc_sense_bsearch.sv
module mlc_sense_bsearch #(
  parameter int NBITS = 3,
  localparam int SW = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [SW-1:0]    step_i,
  input  logic [1:0]       cmp_res_i,
  output logic [NBITS-1:0] ref_o,
  output logic [NBITS-1:0] cur_o
);
  logic [NBITS-1:0] acc_q;
  logic [NBITS-1:0] acc_d;
  logic             fresh;

  // Decision of the previous step comes from the other comparator.
  assign fresh = cmp_res_i[~step_i[0]];

  always_comb begin
    cur_o = acc_q;
    for (int i = 0; i < NBITS; i++) begin
      if (step_i != '0 && i == NBITS - int'(step_i)) begin
        cur_o[i] = fresh;
      end
    end
  end

  always_comb begin
    ref_o = cur_o;
    for (int i = 0; i < NBITS; i++) begin
      if (i == NBITS - 1 - int'(step_i)) begin
        ref_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    acc_d = acc_q;
    if (clr_i) begin
      acc_d = '0;
    end else if (upd_i) begin
      acc_d = cur_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  // The probe always lies above the floor of the range still open.
  assert_ref_above_floor_R3 : assert property (
    @(posedge clk) disable iff (!rst_n) upd_i |-> (ref_o > acc_q));
endmodule

// File: rtl/mlc_sense_ctrl.sv
module mlc_sense_ctrl
  import mlc_sense_pkg::*;
#(
  parameter int NBITS = 3,
  localparam int SW = $clog2(NBITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          par_mode_i,
  output logic [SW-1:0] step_o,
  output logic          clr_o,
  output logic          upd_o,
  output logic [1:0]    pre_o,
  output logic [1:0]    strobe_o,
  output logic          par_strobe_o,
  output logic          fin_seq_o,
  output logic          fin_par_o
);
  localparam logic [SW-1:0] LAST = SW'(NBITS);

  sense_st_e     st_q, st_d;
  logic [SW-1:0] step_q, step_d;

  always_comb begin
    st_d         = st_q;
    step_d       = step_q;
    clr_o        = 1'b0;
    upd_o        = 1'b0;
    pre_o        = 2'b00;
    strobe_o     = 2'b00;
    par_strobe_o = 1'b0;
    fin_seq_o    = 1'b0;
    fin_par_o    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          clr_o = 1'b1;
          st_d  = par_mode_i ? ST_PSMP : ST_PRE;
        end
      end
      ST_PRE: begin
        pre_o[0] = 1'b1;
        step_d   = '0;
        st_d     = ST_RUN;
      end
      ST_RUN: begin
        if (step_q == LAST) begin
          fin_seq_o = 1'b1;
          st_d      = ST_IDLE;
        end else begin
          strobe_o[step_q[0]] = 1'b1;
          if (step_q != LAST - SW'(1)) begin
            pre_o[~step_q[0]] = 1'b1;
          end
          upd_o  = 1'b1;
          step_d = step_q + SW'(1);
        end
      end
      ST_PSMP: begin
        par_strobe_o = 1'b1;
        st_d         = ST_PENC;
      end
      ST_PENC: begin
        fin_par_o = 1'b1;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  assign step_o = step_q;

  assert_strobe0_precharged_R4 : assert property (
    @(posedge clk) disable iff (!rst_n) strobe_o[0] |-> $past(pre_o[0]));
  assert_strobe1_precharged_R4 : assert property (
    @(posedge clk) disable iff (!rst_n) strobe_o[1] |-> $past(pre_o[1]));
  assert_run_continues_R2 : assert property (
    @(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && step_q != LAST) |=> (st_q == ST_RUN));
  assert_busy_start_ignored_R7 : assert property (
    @(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && start_i) |=> (st_q == ST_RUN || st_q == ST_IDLE));
endmodule

// File: rtl/mlc_sense_top.sv
module mlc_sense_top #(
  parameter int NBITS = 3,
  localparam int NREF = (1 << NBITS) - 1,
  localparam int SW = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             par_mode_i,
  input  logic [NREF-1:0]  therm_i,
  input  logic [1:0]       cmp_res_i,
  output logic [NBITS-1:0] ref_sel_o,
  output logic [1:0]       cmp_pre_o,
  output logic [1:0]       cmp_strobe_o,
  output logic             par_strobe_o,
  output logic             done_o,
  output logic [NBITS-1:0] value_o
);
  logic [1:0]       rsync_q;
  logic             rst_sn;
  logic [SW-1:0]    step;
  logic             clr, upd, fin_seq, fin_par;
  logic [NBITS-1:0] cur, cnt;
  logic             done_q, done_d;
  logic [NBITS-1:0] value_q, value_d;

  // Asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_sn = rsync_q[1];

  mlc_sense_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sn),
    .start_i      (start_i),
    .par_mode_i   (par_mode_i),
    .step_o       (step),
    .clr_o        (clr),
    .upd_o        (upd),
    .pre_o        (cmp_pre_o),
    .strobe_o     (cmp_strobe_o),
    .par_strobe_o (par_strobe_o),
    .fin_seq_o    (fin_seq),
    .fin_par_o    (fin_par)
  );

  mlc_sense_bsearch #(.NBITS(NBITS)) u_search (
    .clk       (clk),
    .rst_n     (rst_sn),
    .clr_i     (clr),
    .upd_i     (upd),
    .step_i    (step),
    .cmp_res_i (cmp_res_i),
    .ref_o     (ref_sel_o),
    .cur_o     (cur)
  );

  mlc_sense_therm_enc #(.NBITS(NBITS)) u_enc (
    .therm_i (therm_i),
    .count_o (cnt)
  );

  always_comb begin
    done_d  = fin_seq | fin_par;
    value_d = value_q;
    if (fin_seq) begin
      value_d = cur;
    end else if (fin_par) begin
      value_d = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      done_q  <= 1'b0;
      value_q <= '0;
    end else begin
      done_q  <= done_d;
      value_q <= value_d;
    end
  end

  assign done_o  = done_q;
  assign value_o = value_q;

  assert_done_single_R6 : assert property (
    @(posedge clk) disable iff (!rst_sn) done_q |=> !done_q);
  assert_value_hold_R6 : assert property (
    @(posedge clk) disable iff (!rst_sn) !done_q |-> $stable(value_q));
  assert_one_strobe_R4 : assert property (
    @(posedge clk) disable iff (!rst_sn) $onehot0(cmp_strobe_o));
  assert_mode_exclusive_R8 : assert property (
    @(posedge clk) disable iff (!rst_sn)
      par_strobe_o |-> (cmp_strobe_o == 2'b00 && cmp_pre_o == 2'b00));
endmodule

// File: tb/sim_mlc_sense_top.sv
`timescale 1ns/1ps
module sim_mlc_sense_top;
  localparam int NB = 3;
  localparam int NR = (1 << NB) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, mode;
  logic [NR-1:0] therm_q;
  logic [1:0]    res_q;
  logic [NB-1:0] ref_sel;
  logic [1:0]    cmp_pre, cmp_strobe;
  logic          par_strobe, done;
  logic [NB-1:0] value;

  int            cell_lvl;
  logic [NR-1:0] pat;
  logic          mon_clr;
  int            mon_step, mon_ref_err, mon_pp_err, mon_par;
  logic [1:0]    prev_pre;
  int            tests, fails;

  always #2 clk = ~clk;

  mlc_sense_top #(.NBITS(NB)) u0 (
    .clk (clk), .rst_n (rst_n), .start_i (start), .par_mode_i (mode),
    .therm_i (therm_q), .cmp_res_i (res_q), .ref_sel_o (ref_sel),
    .cmp_pre_o (cmp_pre), .cmp_strobe_o (cmp_strobe),
    .par_strobe_o (par_strobe), .done_o (done), .value_o (value)
  );

  // Comparator models: latch a decision on the strobe edge.
  always @(posedge clk) begin
    if (par_strobe) therm_q <= pat;
    for (int c = 0; c < 2; c++)
      if (cmp_strobe[c]) res_q[c] <= (cell_lvl >= int'(ref_sel));
  end

  // Protocol monitor for R3, R4, R8.
  always @(posedge clk) begin
    if (mon_clr) begin
      mon_step = 0; mon_ref_err = 0; mon_pp_err = 0; mon_par = 0;
    end else begin
      if (|cmp_strobe) begin
        if (mon_step >= NB) mon_ref_err++;
        else begin
          int e;
          e = ((cell_lvl >> (NB - mon_step)) << (NB - mon_step)) | (1 << (NB - 1 - mon_step));
          if (int'(ref_sel) != e) mon_ref_err++;
          if (!cmp_strobe[mon_step % 2] || !prev_pre[mon_step % 2]) mon_pp_err++;
        end
        mon_step++;
      end
      if (|(cmp_strobe & cmp_pre)) mon_pp_err++;
      if (par_strobe) mon_par++;
    end
    prev_pre = cmp_pre;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit par, input int lvl, input logic [NR-1:0] p, input int inject);
    int lat, expv, v0, hold_bad;
    @(negedge clk);
    mon_clr = 1'b1; cell_lvl = lvl; pat = p;
    @(negedge clk);
    mon_clr = 1'b0;
    v0 = int'(value);
    expv = 0;
    if (par) begin
      for (int i = 0; i < NR; i++) expv += int'(p[i]);
    end else expv = lvl;
    lat = par ? 3 : NB + 3;
    start = 1'b1; mode = par;
    @(negedge clk);
    start = 1'b0;
    hold_bad = 0;
    for (int k = 1; k < lat; k++) begin
      if (done || int'(value) != v0) hold_bad++;
      if (k == inject) begin start = 1'b1; mode = !par; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(hold_bad == 0, "R6 value held, done low while busy", hold_bad, 0);
    chk(done == 1'b1, par ? "R5 done latency" : "R2 done latency", int'(done), 1);
    chk(int'(value) == expv, par ? "R5 count of ones" : "R2 serial value", int'(value), expv);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", int'(done), 0);
    chk(int'(value) == expv, "R6 value held after done", int'(value), expv);
    if (par) begin
      chk(mon_par == 1, "R5 one flash strobe", mon_par, 1);
      chk(mon_step == 0, "R8 no serial strobes in flash mode", mon_step, 0);
    end else begin
      chk(mon_step == NB, "R3 strobe count", mon_step, NB);
      chk(mon_ref_err == 0, "R3 reference sequence", mon_ref_err, 0);
      chk(mon_pp_err == 0, "R4 ping-pong precharge", mon_pp_err, 0);
      chk(mon_par == 0, "R8 no flash strobe in serial mode", mon_par, 0);
    end
    if (inject > 0) chk(1'b1 && done == 1'b0, "R7 injected start ignored", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; mon_clr = 1'b1;
    cell_lvl = 0; pat = '0; therm_q = '0; res_q = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(value == '0, "R1 value after reset", int'(value), 0);
    chk(cmp_pre == 2'b00 && cmp_strobe == 2'b00, "R1 comparator controls idle",
        int'({cmp_pre, cmp_strobe}), 0);
    chk(par_strobe == 1'b0, "R1 flash strobe idle", int'(par_strobe), 0);
    // R2/R3/R4: every level, serial
    for (int l = 0; l <= NR; l++) run_op(1'b0, l, '0, 0);
    // R5: every thermometer word, clean and bubbled
    for (int p = 0; p < (1 << NR); p++) run_op(1'b1, 0, NR'(p), 0);
    // R7: second start mid-read in the other mode
    for (int k = 1; k < NB + 3; k++) run_op(1'b0, (k * 3) % (NR + 1), '0, k);
    run_op(1'b1, 0, NR'(7'b0010111), 1);
    run_op(1'b1, 0, NR'(7'b1111111), 2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule